// File: doc/BRIEF.md
# Windowed Key-Service Watchdog

This block is a watchdog timer that a bus master keeps quiet by writing an 8-bit key register. A 3-bit rate field in a control register turns the watchdog off (code zero) or selects one of seven time-out periods. Restarting the period takes an ordered pair of key writes: first 0x55, later 0xAA, with any other bus traffic allowed in between. A key write of any other value, or a period that runs out before the pair is complete, raises a single-cycle active-high reset request.

An optional window mode tightens the rule: while it is on, any key write that lands in the first three quarters of the period is itself a fault. A sticky cause register records which kind of fault occurred (bad value, early write or time-out), and software clears its bits by writing ones to them. The register interface is a one-cycle write strobe with address and data, plus a combinational read port.

Period for rate code k (1 to 7) is 2^(BASE_SHIFT + STEP_SHIFT*k) clock cycles; with the defaults (8 and 2) this gives 2^10 up to 2^22 cycles.

Top module: `wdt_keyguard`

## Requirements
- R1: Reading the key register (address 1) always returns 0x00, whatever has been written.
- R2: While the rate field (control bits [2:0], address 0) is 000, key writes of any value have no effect: no reset pulse occurs and the cause register stays unchanged.
- R3: With a nonzero rate code k and no service, the reset pulse appears exactly 2^(BASE_SHIFT+STEP_SHIFT*k) cycles after the control write that enabled or last restarted the period, and the cause register bit 2 (time-out) is set.
- R4: While enabled, a key write of any value other than 0x55 or 0xAA produces the reset pulse on the following cycle and sets cause bit 0 (bad value).
- R5: A 0x55 key write followed later by a 0xAA key write restarts the period from zero, even with other register accesses between them; the next time-out then comes a full period after the 0xAA write.
- R6: Repeated 0x55 writes, and a 0xAA write with no earlier 0x55, cause no reset; a lone 0xAA does not restart the period.
- R7: With the window bit (control bit 3) set, a key write of any value while fewer than three quarters of the period have elapsed produces the reset pulse on the next cycle and sets cause bit 1 (early); a 0x55/0xAA pair written in the last quarter restarts the period.
- R8: After a reset pulse or a successful service the counter restarts at zero and the sequence returns to waiting for 0x55, so a 0xAA right afterwards does not restart the period.
- R9: The reset output is high for one cycle per fault; cause bits (read at address 2 as {5'b0, timeout, early, bad}) are sticky and are cleared by writing 1 to them at address 2.
- R10: A control write that changes the rate field restarts the counter from zero.
- R11: The synchronous reset clears the control register, the cause register, the counter, the sequence state and the reset output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 2 | Write address: 0 control, 1 key, 2 cause |
| reg_wdata | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| wdt_reset | output | 1 | Single-cycle watchdog reset request |

## Verification
On every cycle the checker confirms that the key register reads zero, that a disabled watchdog never fires, that the counter stays within the selected period, that a bad value or an early window write fires on the next cycle, that every pulse leaves the counter and sequence cleared with a cause bit set, and that a rate change restarts the count. Only the bench scenarios can show the exact time-out distance for each period, that a completed 0x55/0xAA pair pushes the next time-out a full period out, that a lone 0xAA leaves the schedule untouched, and that write-one-to-clear on the cause bits works against long random traffic checked by a cycle model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_KEY   = 2'd1,
        REG_CAUSE = 2'd2,
        REG_SPARE = 2'd3
    } reg_addr_e;

    localparam logic [7:0] KEY_ARM  = 8'h55;
    localparam logic [7:0] KEY_FIRE = 8'hAA;

    typedef struct packed {
        logic       win;
        logic [2:0] rate;
    } ctrl_t;

    typedef struct packed {
        logic tmo;
        logic early;
        logic badv;
    } cause_t;

    function automatic logic is_key_value(input logic [7:0] v);
        return (v == KEY_ARM) || (v == KEY_FIRE);
    endfunction

    function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
        return {4'b0, c.win, c.rate};
    endfunction

endpackage

// File: rtl/wdt_limit.sv
module wdt_limit #(
    parameter int unsigned BASE_SHIFT = 8,
    parameter int unsigned STEP_SHIFT = 2,
    parameter int unsigned CNT_W      = BASE_SHIFT + STEP_SHIFT * 7
) (
    input  logic [2:0]       rate,
    output logic [CNT_W-1:0] last,
    output logic [CNT_W-1:0] early_lim
);
    logic [CNT_W-1:0] last_tab  [8];
    logic [CNT_W-1:0] early_tab [8];

    for (genvar k = 0; k < 8; k++) begin : g_code
        if (k == 0) begin : g_off
            assign last_tab[k]  = '0;
            assign early_tab[k] = '0;
        end else begin : g_on
            localparam int unsigned EXP = BASE_SHIFT + STEP_SHIFT * k;
            assign last_tab[k]  = CNT_W'((64'd1 << EXP) - 64'd1);
            assign early_tab[k] = CNT_W'(64'd3 << (EXP - 2));
        end
    end

    assign last      = last_tab[rate];
    assign early_lim = early_tab[rate];
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int unsigned CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [CNT_W-1:0] last,
    input  logic [CNT_W-1:0] early_lim,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last,
    output logic             in_early
);
    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else              cnt <= cnt + CNT_W'(1);
    end

    assign at_last  = (cnt == last);
    assign in_early = (cnt < early_lim);
endmodule

// File: rtl/wdt_seq.sv
module wdt_seq
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    input  logic       win,
    input  logic       in_early,
    input  logic       drop,
    output logic       service,
    output logic       bad_val,
    output logic       early_hit,
    output logic       armed
);
    logic kw;

    assign kw        = key_wr && en;
    assign early_hit = kw && win && in_early;
    assign bad_val   = kw && !early_hit && !is_key_value(key_data);
    assign service   = kw && !early_hit && armed && (key_data == KEY_FIRE);

    always_ff @(posedge clk) begin
        if (rst || !en || drop || service) armed <= 1'b0;
        else if (kw && key_data == KEY_ARM) armed <= 1'b1;
    end
endmodule

// File: rtl/wdt_keyguard.sv
module wdt_keyguard
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_SHIFT = 8,
    parameter int unsigned STEP_SHIFT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       wdt_reset
);
    localparam int unsigned CNT_W = BASE_SHIFT + STEP_SHIFT * 7;

    ctrl_t            ctrl_q;
    cause_t           cause_q, cause_set;
    logic [CNT_W-1:0] cnt_q, last_q, early_lim;
    logic             en, at_last, in_early;
    logic             wr_ctrl, wr_key, wr_cause, rate_chg;
    logic             service, bad_val, early_hit, armed_q, tmo, fire;

    assign wr_ctrl  = reg_wr && (reg_addr_e'(reg_addr) == REG_CTRL);
    assign wr_key   = reg_wr && (reg_addr_e'(reg_addr) == REG_KEY);
    assign wr_cause = reg_wr && (reg_addr_e'(reg_addr) == REG_CAUSE);
    assign en       = (ctrl_q.rate != 3'd0);
    assign rate_chg = wr_ctrl && (reg_wdata[2:0] != ctrl_q.rate);

    wdt_limit #(
        .BASE_SHIFT(BASE_SHIFT),
        .STEP_SHIFT(STEP_SHIFT),
        .CNT_W     (CNT_W)
    ) u_limit (
        .rate     (ctrl_q.rate),
        .last     (last_q),
        .early_lim(early_lim)
    );

    wdt_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .key_wr   (wr_key),
        .key_data (reg_wdata),
        .win      (ctrl_q.win),
        .in_early (in_early),
        .drop     (fire),
        .service  (service),
        .bad_val  (bad_val),
        .early_hit(early_hit),
        .armed    (armed_q)
    );

    assign tmo  = en && at_last && !service && !bad_val && !early_hit;
    assign fire = tmo || bad_val || early_hit;

    wdt_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .clear    (!en || fire || service || rate_chg),
        .last     (last_q),
        .early_lim(early_lim),
        .cnt      (cnt_q),
        .at_last  (at_last),
        .in_early (in_early)
    );

    always_comb begin
        cause_set       = '0;
        cause_set.tmo   = tmo;
        cause_set.early = early_hit;
        cause_set.badv  = bad_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            cause_q   <= '0;
            wdt_reset <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[3:0]);
            cause_q   <= (cause_q & ~(wr_cause ? cause_t'(reg_wdata[2:0]) : cause_t'(3'b0)))
                         | cause_set;
            wdt_reset <= fire;
        end
    end

    always_comb begin
        unique case (reg_addr_e'(rd_addr))
            REG_CTRL:  rd_data = ctrl_to_byte(ctrl_q);
            REG_CAUSE: rd_data = {5'b0, cause_q};
            default:   rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/wdt_keyguard_chk.sv
module wdt_keyguard_chk #(
    parameter int unsigned CNT_W = 22
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [7:0]       reg_wdata,
    input logic [1:0]       rd_addr,
    input logic [7:0]       rd_data,
    input logic             wdt_reset,
    input logic [2:0]       rate_q,
    input logic             win_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] last_q,
    input logic [CNT_W-1:0] early_lim,
    input logic             armed_q,
    input logic [2:0]       cause_q
);
    logic key_wr_en;
    assign key_wr_en = reg_wr && (reg_addr == 2'd1) && (rate_q != 3'd0);

    assert_key_reads_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == 2'd1) |-> (rd_data == 8'h00));

    assert_off_no_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        (rate_q == 3'd0) |=> !wdt_reset);

    assert_count_in_period_R3: assert property (@(posedge clk) disable iff (rst)
        (rate_q != 3'd0) |-> (cnt_q <= last_q));

    assert_bad_value_fires_R4: assert property (@(posedge clk) disable iff (rst)
        (key_wr_en && reg_wdata != 8'h55 && reg_wdata != 8'hAA) |=> wdt_reset);

    assert_early_write_fires_R7: assert property (@(posedge clk) disable iff (rst)
        (key_wr_en && win_q && cnt_q < early_lim) |=> (wdt_reset && cause_q[1]));

    assert_pulse_clears_state_R8: assert property (@(posedge clk) disable iff (rst)
        wdt_reset |-> (cnt_q == '0 && !armed_q));

    assert_pulse_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
        wdt_reset |-> (cause_q != 3'b000));

    assert_rate_change_restarts_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[2:0] != rate_q) |=> (cnt_q == '0));
endmodule

bind wdt_keyguard wdt_keyguard_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wdt_reset(wdt_reset),
    .rate_q   (ctrl_q.rate),
    .win_q    (ctrl_q.win),
    .cnt_q    (cnt_q),
    .last_q   (last_q),
    .early_lim(early_lim),
    .armed_q  (armed_q),
    .cause_q  (cause_q)
);

// File: tb/wdt_keyguard_test.sv
module wdt_keyguard_test;
    localparam int BASE = 2;
    localparam int STEP = 1;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [1:0] rd_addr;
    logic [7:0] rd_data;
    logic       wdt_reset;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int pulses = 0;
    bit done  = 0;

    // reference model state
    int       m_cnt;
    bit       m_armed;
    bit [2:0] m_rate;
    bit       m_win;
    bit [2:0] m_cause;   // {timeout, early, bad}
    bit       m_pulse;

    always #5 clk = ~clk;

    wdt_keyguard #(.BASE_SHIFT(BASE), .STEP_SHIFT(STEP)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .wdt_reset(wdt_reset)
    );

    function automatic int period(input bit [2:0] r);
        return 1 << (BASE + STEP * r);
    endfunction

    function automatic bit [7:0] exp_read(input bit [1:0] a);
        case (a)
            2'd0:    return {4'b0, m_win, m_rate};
            2'd2:    return {5'b0, m_cause};
            default: return 8'h00;
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_armed = 0; m_rate = 0; m_win = 0; m_cause = 0; m_pulse = 0;
    endtask

    task automatic model_edge(input bit wr, input bit [1:0] a, input bit [7:0] d);
        bit en, kw, early, badv, serv, tmo, fire;
        int p;
        en    = (m_rate != 0);
        p     = period(m_rate);
        kw    = wr && a == 2'd1 && en;
        early = kw && m_win && (m_cnt < (p * 3) / 4);
        badv  = kw && !early && d != 8'h55 && d != 8'hAA;
        serv  = kw && !early && d == 8'hAA && m_armed;
        tmo   = en && (m_cnt == p - 1) && !serv && !early && !badv;
        fire  = tmo || early || badv;
        m_cause = (m_cause & ~((wr && a == 2'd2) ? d[2:0] : 3'b0)) | {tmo, early, badv};
        if (!en || fire || serv || (wr && a == 2'd0 && d[2:0] != m_rate)) m_cnt = 0;
        else m_cnt++;
        if (!en || fire || serv) m_armed = 0;
        else if (kw && d == 8'h55) m_armed = 1;
        if (wr && a == 2'd0) begin m_rate = d[2:0]; m_win = d[3]; end
        m_pulse = fire;
    endtask

    // one clock: drive, edge, model, sample at falling edge
    task automatic step(input bit wr, input bit [1:0] a, input bit [7:0] d);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        if (rst) model_reset(); else model_edge(wr, a, d);
        @(negedge clk);
        if (wdt_reset) pulses++;
        chk("R3 pulse vs model", wdt_reset, m_pulse);
        chk("R9 read vs model", rd_data, exp_read(rd_addr));
        reg_wr = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 2'd0, 8'h00);
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            step(0, 2'd0, 8'h00);
            n++;
        end while (!wdt_reset && n < 5000);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        int n;
        rst = 1; reg_wr = 0; reg_addr = 0; reg_wdata = 0; rd_addr = 2'd2;
        model_reset();
        step(0, 2'd0, 8'h00);
        step(0, 2'd0, 8'h00);
        rst = 0;
        // R11 reset state
        chk("R11 pulse after reset", wdt_reset, 0);
        chk("R11 cause after reset", rd_data, 0);
        rd_addr = 2'd0; #1;
        chk("R11 ctrl after reset", rd_data, 0);
        rd_addr = 2'd2;

        // R2 disabled: key writes ignored
        pulses = 0;
        step(1, 2'd1, 8'h13);
        step(1, 2'd1, 8'h55);
        idle(600);
        chk("R2 no pulse while off", pulses, 0);
        chk("R2 cause untouched while off", rd_data, 0);

        // R3 timeout distance, rate 1 and 3
        step(1, 2'd0, 8'h01);
        wait_pulse(n);
        chk("R3 timeout distance rate1", n, 8);
        chk("R3 timeout cause bit2", rd_data, 4);
        step(0, 2'd0, 8'h00);
        chk("R9 pulse lasts one cycle", wdt_reset, 0);
        chk("R9 cause sticky", rd_data, 4);
        step(1, 2'd2, 8'h04);
        chk("R9 cause cleared by write one", rd_data, 0);
        step(1, 2'd0, 8'h03);
        wait_pulse(n);
        chk("R3 timeout distance rate3", n, 32);

        // R4 bad value
        step(1, 2'd2, 8'h07);
        step(1, 2'd0, 8'h02);
        step(1, 2'd1, 8'h12);
        chk("R4 bad value pulse", wdt_reset, 1);
        chk("R4 bad value cause bit0", rd_data, 1);

        // R5 ordered pair with other traffic between
        step(1, 2'd2, 8'h07);
        step(1, 2'd0, 8'h03);
        pulses = 0;
        idle(10);
        step(1, 2'd1, 8'h55);
        rd_addr = 2'd0;
        step(0, 2'd0, 8'h00);
        step(1, 2'd2, 8'h00);
        idle(3);
        rd_addr = 2'd2;
        step(1, 2'd1, 8'hAA);
        chk("R5 no pulse from service", pulses, 0);
        wait_pulse(n);
        chk("R5 next timeout a full period after 0xAA", n, 32);

        // R6 lone 0xAA and repeated 0x55
        step(1, 2'd0, 8'h02);
        step(1, 2'd1, 8'hAA);
        wait_pulse(n);
        chk("R6 lone 0xAA does not restart", n, 15);
        pulses = 0;
        step(1, 2'd1, 8'h55);
        step(1, 2'd1, 8'h55);
        step(1, 2'd1, 8'h55);
        step(1, 2'd1, 8'hAA);
        chk("R6 repeated 0x55 then 0xAA no pulse", pulses, 0);

        // R8 sequence cleared after service
        step(1, 2'd1, 8'hAA);
        wait_pulse(n);
        chk("R8 0xAA right after service does not restart", n, 15);

        // R7 window mode
        step(1, 2'd2, 8'h07);
        step(1, 2'd0, 8'h09);
        idle(2);
        step(1, 2'd1, 8'h55);
        chk("R7 early write pulse", wdt_reset, 1);
        chk("R7 early cause bit1", rd_data, 2);
        pulses = 0;
        idle(6);
        step(1, 2'd1, 8'h55);
        step(1, 2'd1, 8'hAA);
        chk("R7 late pair services", pulses, 0);
        wait_pulse(n);
        chk("R7 period restarted by late pair", n, 8);

        // R10 rate change restarts
        step(1, 2'd0, 8'h03);
        idle(20);
        step(1, 2'd0, 8'h02);
        wait_pulse(n);
        chk("R10 rate change restart", n, 16);

        // R1 key reads zero
        step(1, 2'd1, 8'h55);
        rd_addr = 2'd1; #1;
        chk("R1 key reads zero", rd_data, 0);

        // R11 reset mid-run
        step(1, 2'd0, 8'h0B);
        rst = 1;
        step(0, 2'd0, 8'h00);
        rst = 0;
        rd_addr = 2'd0; #1;
        chk("R11 ctrl cleared by reset", rd_data, 0);
        rd_addr = 2'd2; #1;
        chk("R11 cause cleared by reset", rd_data, 0);

        // constrained random traffic against the model
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 6000; i++) begin
            int sel;
            bit [7:0] d;
            sel = $urandom_range(0, 99);
            rd_addr = 2'($urandom_range(0, 3));
            if (sel < 55) begin
                step(0, 2'd0, 8'h00);
            end else if (sel < 75) begin
                step(1, 2'd1, 8'h55);
            end else if (sel < 92) begin
                step(1, 2'd1, 8'hAA);
            end else if (sel < 94) begin
                d = 8'($urandom_range(0, 255));
                step(1, 2'd1, d);
            end else if (sel < 97) begin
                d = {4'b0, 1'($urandom_range(0, 1)), 3'($urandom_range(0, 3))};
                step(1, 2'd0, d);
            end else begin
                d = 8'($urandom_range(0, 7));
                step(1, 2'd2, d);
            end
        end

        finish_run();
    end
endmodule